// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This block is a 32-bit processor that finishes every instruction in one clock. Each cycle it fetches a word from a small internal instruction store at the current program counter. A combinational decoder turns that word into fixed multiplexer controls. Four pieces of logic then carry out the instruction. A 32-entry register file supplies two operands. An immediate extender feeds an add/subtract/OR unit. A word-addressed data store serves loads and stores. A next-address unit selects the sequential address, a branch target or a jump target. Branch-if-equal compares the two register operands directly, without using the arithmetic result.

The instruction store has a plain write port. The program is placed there while reset is held high. After reset is released, the core runs from address zero. A registered retirement trace shows one cycle later what each instruction committed: its address, any register write and any memory write. The current program counter is also brought out. These outputs are the only view of the core's state.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high (synchronous, active high) no register or memory write commits. From the first clock edge after `rst` was high, `pc_o` is 0 and `tr_valid`, `tr_rf_we` and `tr_dm_we` are 0.
- R2: Opcode 6'h00 (bits [31:26]) with funct 6'h20 (bits [5:0]) writes rs+rt into rd. With funct 6'h22 it writes rs−rt into rd. Register numbers are rs [25:21], rt [20:16] and rd [15:11]. Results wrap modulo 2^32.
- R3: Opcode 6'h0D writes rs OR the zero-extended imm16 [15:0] into rt.
- R4: Opcode 6'h23 writes into rt the data word at byte address rs + sign-extended imm16. The word is selected by address bits [9:2].
- R5: Opcode 6'h2B stores rt into the data word at rs + sign-extended imm16 (word selected by bits [9:2]). It writes no register.
- R6: Opcode 6'h04 moves the PC to PC+4 + (sign-extended imm16 × 4) when rs equals rt, and to PC+4 otherwise. It writes nothing.
- R7: Opcode 6'h02 moves the PC to {upper 4 bits of PC+4, target [25:0], 2'b00}. It writes nothing.
- R8: Register 0 reads as zero. An instruction that targets it commits no register write.
- R9: Any other opcode, and opcode 6'h00 with any funct other than 6'h20 or 6'h22, writes nothing and advances the PC by 4.
- R10: Every instruction retires in one cycle. On the next edge the trace holds its PC, the register write (enable, number, data) and the memory write (enable, byte address, data), and `pc_o` holds the next PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | IMEM_AW | Instruction store word address |
| imem_wdata | input | 32 | Instruction word to store |
| pc_o | output | 32 | Current program counter |
| tr_valid | output | 1 | An instruction retired on the last edge |
| tr_pc | output | 32 | Address of the retired instruction |
| tr_rf_we | output | 1 | Retired instruction wrote a register |
| tr_rf_addr | output | RF_AW | Register number written |
| tr_rf_data | output | 32 | Value written to the register |
| tr_dm_we | output | 1 | Retired instruction wrote data memory |
| tr_dm_addr | output | 32 | Byte address of the store |
| tr_dm_data | output | 32 | Value stored |

## Verification
Some properties are checked on every cycle. These are: the reset state, that register 0 is never a committed destination, that a store never also writes a register, the +4 step for every non-redirecting instruction, and the upper-bit and alignment form of jump targets. Only the bench's program can show that the arithmetic, the zero and sign extension, the load data path, and the taken and not-taken branch targets carry the right values. The program runs a behavioural model beside the core and compares the trace after every edge. It covers a negative displacement, a forward and a self-looping branch, and both kinds of undefined encoding.

// File: rtl/sc_pkg.sv
package sc_pkg;

  typedef enum logic [5:0] {
    OP_RTYPE = 6'h00,
    OP_JUMP  = 6'h02,
    OP_BEQ   = 6'h04,
    OP_ORI   = 6'h0D,
    OP_LW    = 6'h23,
    OP_SW    = 6'h2B
  } opcode_e;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;    // 1: write rd, 0: write rt
    logic    src_imm;   // 1: second operand is extended immediate
    logic    wb_mem;    // 1: write back data memory word
    logic    ext_sign;  // 1: sign extend imm16, 0: zero extend
    logic    rf_we;
    logic    dm_we;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctrl
);

  opcode_e    op;
  logic [5:0] funct;

  assign op    = opcode_e'(instr[31:26]);
  assign funct = instr[5:0];

  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    case (op)
      OP_RTYPE: begin
        if (funct == FN_ADD) begin
          ctrl.dst_rd = 1'b1;
          ctrl.rf_we  = 1'b1;
        end else if (funct == FN_SUB) begin
          ctrl.dst_rd = 1'b1;
          ctrl.rf_we  = 1'b1;
          ctrl.alu_op = ALU_SUB;
        end
      end
      OP_ORI: begin
        ctrl.src_imm = 1'b1;
        ctrl.rf_we   = 1'b1;
        ctrl.alu_op  = ALU_OR;
      end
      OP_LW: begin
        ctrl.src_imm  = 1'b1;
        ctrl.ext_sign = 1'b1;
        ctrl.wb_mem   = 1'b1;
        ctrl.rf_we    = 1'b1;
      end
      OP_SW: begin
        ctrl.src_imm  = 1'b1;
        ctrl.ext_sign = 1'b1;
        ctrl.dm_we    = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OP_JUMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] ra_data,
  output logic [DW-1:0] rb_data,
  output logic          wr_done
);

  localparam int NREG = 1 << AW;

  logic [DW-1:0] regs [NREG];

  assign wr_done = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_done) regs[waddr] <= wdata;
  end

  assign ra_data = (ra_addr == '0) ? '0 : regs[ra_addr];
  assign rb_data = (rb_addr == '0) ? '0 : regs[rb_addr];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         eq
);

  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end

  // equality for branches is a direct comparator, not a zero test on y
  assign eq = (a == b);

endmodule

// File: rtl/sc_ram.sv
module sc_ram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 8,
  parameter int RF_AW   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               imem_we,
  input  logic [IMEM_AW-1:0] imem_waddr,
  input  logic [31:0]        imem_wdata,
  output logic [31:0]        pc_o,
  output logic               tr_valid,
  output logic [31:0]        tr_pc,
  output logic               tr_rf_we,
  output logic [RF_AW-1:0]   tr_rf_addr,
  output logic [31:0]        tr_rf_data,
  output logic               tr_dm_we,
  output logic [31:0]        tr_dm_addr,
  output logic [31:0]        tr_dm_data
);

  localparam int XW = 32;
  localparam int IMM_W = 16;
  localparam int TGT_W = 26;

  logic [XW-1:0]    pc_q, pc_next, pc_plus4, br_target, jmp_target;
  logic [XW-1:0]    instr;
  ctrl_t            ctrl;
  logic [RF_AW-1:0] rs_f, rt_f, rd_f, wr_reg;
  logic [IMM_W-1:0] imm16;
  logic [XW-1:0]    imm_ext, ra_val, rb_val, alu_b, alu_y, dm_rdata, wb_data;
  logic             eq, rf_we_eff, dm_we_eff, rf_wr_done;

  // ---------------- fetch ----------------
  sc_ram #(.AW(IMEM_AW), .DW(XW)) u_imem (
    .clk(clk), .we(imem_we), .waddr(imem_waddr), .wdata(imem_wdata),
    .raddr(pc_q[IMEM_AW+1:2]), .rdata(instr)
  );

  // ---------------- decode ----------------
  assign rs_f  = instr[25:21];
  assign rt_f  = instr[20:16];
  assign rd_f  = instr[15:11];
  assign imm16 = instr[15:0];

  sc_decode u_dec (.instr(instr), .ctrl(ctrl));

  assign rf_we_eff = ctrl.rf_we & ~rst;
  assign dm_we_eff = ctrl.dm_we & ~rst;
  assign wr_reg    = ctrl.dst_rd ? rd_f : rt_f;

  // ---------------- operands ----------------
  sc_regfile #(.AW(RF_AW), .DW(XW)) u_rf (
    .clk(clk), .we(rf_we_eff), .waddr(wr_reg), .wdata(wb_data),
    .ra_addr(rs_f), .rb_addr(rt_f), .ra_data(ra_val), .rb_data(rb_val),
    .wr_done(rf_wr_done)
  );

  assign imm_ext = ctrl.ext_sign ? {{(XW-IMM_W){imm16[IMM_W-1]}}, imm16}
                                 : {{(XW-IMM_W){1'b0}}, imm16};
  assign alu_b   = ctrl.src_imm ? imm_ext : rb_val;

  sc_alu #(.W(XW)) u_alu (
    .op(ctrl.alu_op), .a(ra_val), .b(alu_b), .y(alu_y), .eq(eq)
  );

  // ---------------- data memory ----------------
  sc_ram #(.AW(DMEM_AW), .DW(XW)) u_dmem (
    .clk(clk), .we(dm_we_eff), .waddr(alu_y[DMEM_AW+1:2]), .wdata(rb_val),
    .raddr(alu_y[DMEM_AW+1:2]), .rdata(dm_rdata)
  );

  assign wb_data = ctrl.wb_mem ? dm_rdata : alu_y;

  // ---------------- next PC ----------------
  assign pc_plus4   = pc_q + XW'(4);
  assign br_target  = pc_plus4 + {{(XW-IMM_W-2){imm16[IMM_W-1]}}, imm16, 2'b00};
  assign jmp_target = {pc_plus4[XW-1:TGT_W+2], instr[TGT_W-1:0], 2'b00};

  always_comb begin
    if (ctrl.jump)             pc_next = jmp_target;
    else if (ctrl.branch && eq) pc_next = br_target;
    else                        pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc_o = pc_q;

  // ---------------- retirement trace ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      tr_valid   <= 1'b0;
      tr_pc      <= '0;
      tr_rf_we   <= 1'b0;
      tr_rf_addr <= '0;
      tr_rf_data <= '0;
      tr_dm_we   <= 1'b0;
      tr_dm_addr <= '0;
      tr_dm_data <= '0;
    end else begin
      tr_valid   <= 1'b1;
      tr_pc      <= pc_q;
      tr_rf_we   <= rf_wr_done;
      tr_rf_addr <= wr_reg;
      tr_rf_data <= wb_data;
      tr_dm_we   <= dm_we_eff;
      tr_dm_addr <= alu_y;
      tr_dm_data <= rb_val;
    end
  end

  // ---------------- assertions ----------------
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && !tr_valid && !tr_rf_we && !tr_dm_we));

  a_r8_no_r0_commit: assert property (@(posedge clk) disable iff (rst)
    tr_rf_we |-> (tr_rf_addr != '0));

  a_r5_store_no_regwrite: assert property (@(posedge clk) disable iff (rst)
    tr_dm_we |-> !tr_rf_we);

  a_r9_sequential_step: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.jump && !(ctrl.branch && eq)) |=> (pc_q == $past(pc_q) + XW'(4)));

  a_r7_jump_region: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> (pc_q[1:0] == 2'b00 && pc_q[XW-1:TGT_W+2] == $past(pc_plus4[XW-1:TGT_W+2])));

  a_r6_branch_quiet: assert property (@(posedge clk) disable iff (rst)
    ctrl.branch |=> (!tr_rf_we && !tr_dm_we));

endmodule

// File: tb/sc_core_bench.sv
module sc_core_bench;

  localparam int IAW = 8;
  localparam int RAW = 5;

  logic            clk = 1'b0;
  logic            rst;
  logic            imem_we;
  logic [IAW-1:0]  imem_waddr;
  logic [31:0]     imem_wdata;
  logic [31:0]     pc_o, tr_pc, tr_rf_data, tr_dm_addr, tr_dm_data;
  logic            tr_valid, tr_rf_we, tr_dm_we;
  logic [RAW-1:0]  tr_rf_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sc_core u_sc_core (
    .clk(clk), .rst(rst), .imem_we(imem_we), .imem_waddr(imem_waddr),
    .imem_wdata(imem_wdata), .pc_o(pc_o), .tr_valid(tr_valid), .tr_pc(tr_pc),
    .tr_rf_we(tr_rf_we), .tr_rf_addr(tr_rf_addr), .tr_rf_data(tr_rf_data),
    .tr_dm_we(tr_dm_we), .tr_dm_addr(tr_dm_addr), .tr_dm_data(tr_dm_data)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] prog [256];
  logic [31:0] mregs [32];
  logic [31:0] mdm [256];
  logic [31:0] mpc;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] tgt);
    return {op, tgt};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step_and_compare();
    logic [31:0] ins, a, b, res, sx, zx, addr, npc;
    logic [5:0]  op, fn;
    int          rs, rt, rd;
    logic        e_rwe, e_dwe;
    int          e_rad;
    logic [31:0] e_rdat, e_dadr, e_ddat;
    string       req;
    ins = prog[mpc[9:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    a = (rs == 0) ? 32'h0 : mregs[rs];
    b = (rt == 0) ? 32'h0 : mregs[rt];
    sx = {{16{ins[15]}}, ins[15:0]};
    zx = {16'h0, ins[15:0]};
    npc = mpc + 4;
    e_rwe = 0; e_dwe = 0; e_rad = 0; e_rdat = 0; e_dadr = 0; e_ddat = 0;
    req = "R9";
    case (op)
      6'h00: begin
        if (fn == 6'h20 || fn == 6'h22) begin
          res = (fn == 6'h20) ? a + b : a - b;
          req = (rd == 0) ? "R8" : "R2";
          e_rwe = (rd != 0); e_rad = rd; e_rdat = res;
        end
      end
      6'h0D: begin
        req = (rt == 0) ? "R8" : "R3";
        e_rwe = (rt != 0); e_rad = rt; e_rdat = a | zx;
      end
      6'h23: begin
        req = "R4"; addr = a + sx;
        e_rwe = (rt != 0); e_rad = rt; e_rdat = mdm[addr[9:2]];
      end
      6'h2B: begin
        req = "R5"; addr = a + sx;
        e_dwe = 1; e_dadr = addr; e_ddat = b;
      end
      6'h04: begin
        req = "R6";
        if (a == b) npc = mpc + 4 + {sx[29:0], 2'b00};
      end
      6'h02: begin
        req = "R7";
        npc = {npc[31:28], ins[25:0], 2'b00};
      end
      default: req = "R9";
    endcase
    chk("R10", "tr_valid", 32'(tr_valid), 32'h1);
    chk("R10", "tr_pc", tr_pc, mpc);
    chk(req, "tr_rf_we", 32'(tr_rf_we), 32'(e_rwe));
    if (e_rwe) begin
      chk(req, "tr_rf_addr", 32'(tr_rf_addr), 32'(e_rad));
      chk(req, "tr_rf_data", tr_rf_data, e_rdat);
    end
    chk(req, "tr_dm_we", 32'(tr_dm_we), 32'(e_dwe));
    if (e_dwe) begin
      chk(req, "tr_dm_addr", tr_dm_addr, e_dadr);
      chk(req, "tr_dm_data", tr_dm_data, e_ddat);
    end
    chk(req, "pc_o", pc_o, npc);
    if (e_rwe) mregs[e_rad] = e_rdat;
    if (e_dwe) mdm[e_dadr[9:2]] = e_ddat;
    mpc = npc;
  endtask

  task automatic check_reset_state();
    chk("R1", "pc_o", pc_o, 32'h0);
    chk("R1", "tr_valid", 32'(tr_valid), 32'h0);
    chk("R1", "tr_rf_we", 32'(tr_rf_we), 32'h0);
    chk("R1", "tr_dm_we", 32'(tr_dm_we), 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      prog[i] = 32'hFC00_0000;          // undefined opcode everywhere else
      mdm[i] = 32'h0;
    end
    for (int i = 0; i < 32; i++) mregs[i] = 32'h0;
    prog[0]  = enc_i(6'h0D, 0, 1, 16'h8005);       // R3 zero extension
    prog[1]  = enc_i(6'h0D, 0, 2, 16'h0003);
    prog[2]  = enc_r(1, 2, 3, 6'h20);              // R2 add
    prog[3]  = enc_r(2, 1, 4, 6'h22);              // R2 sub, wraps
    prog[4]  = enc_i(6'h2B, 0, 3, 16'h0008);       // R5 store
    prog[5]  = enc_i(6'h0D, 0, 5, 16'h0040);
    prog[6]  = enc_i(6'h2B, 5, 4, 16'hFFF8);       // R5 negative displacement
    prog[7]  = enc_i(6'h23, 5, 6, 16'hFFF8);       // R4 load back
    prog[8]  = enc_i(6'h23, 0, 7, 16'h0008);       // R4
    prog[9]  = enc_i(6'h0D, 1, 0, 16'h1234);       // R8 write to r0 dropped
    prog[10] = enc_r(0, 1, 8, 6'h20);              // R8 r0 reads zero
    prog[11] = enc_i(6'h04, 1, 2, 16'h0005);       // R6 not taken
    prog[12] = enc_i(6'h04, 3, 7, 16'h0002);       // R6 taken forward
    prog[13] = enc_i(6'h0D, 0, 9, 16'h0BAD);
    prog[14] = enc_i(6'h0D, 0, 9, 16'h0BAD);
    prog[15] = enc_j(6'h02, 26'd18);               // R7 jump
    prog[16] = enc_i(6'h0D, 0, 9, 16'h0BAD);
    prog[17] = enc_i(6'h0D, 0, 9, 16'h0BAD);
    prog[18] = 32'hFC00_0000;                      // R9 undefined opcode
    prog[19] = enc_r(1, 2, 10, 6'h25);             // R9 undefined funct
    prog[20] = enc_i(6'h04, 0, 0, 16'hFFFF);       // R6 self loop
    mpc = 32'h0;

    rst = 1'b1; imem_we = 1'b0; imem_waddr = '0; imem_wdata = '0;
    repeat (2) @(negedge clk);
    check_reset_state();
    for (int i = 0; i < 256; i++) begin
      imem_we = 1'b1; imem_waddr = IAW'(i); imem_wdata = prog[i];
      @(negedge clk);
    end
    imem_we = 1'b0;
    check_reset_state();
    rst = 1'b0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      step_and_compare();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule